// File: doc/BRIEF.md
# Bus Release Arbitration Controller

This controller sits on the master side of a processor's external bus. By default the master owns the bus and drives its address, data and control groups. An external device asks for the bus by pulling an active-low release request. The controller then stops new master cycles and lets the cycle in flight finish. It issues a one-shot precharge request to the memory controller and waits until precharge completes. Only then does it hand the bus over, with an active-low grant and a staged turn-off of the three output-enable groups. When the request is withdrawn, it negates the grant and turns the drivers back on, also in stages.

Both clock edges matter, so the block runs from one clock at twice the bus rate (`clk2x`) and keeps a phase bit. Each `clk2x` edge stands for one half-cycle of the bus clock and is either a "falling" or a "rising" bus edge. The output `next_is_fall` tells the surrounding logic which kind of edge comes next. Control strobes are held at their negated level, through `ctrl_negate`, for a parameterised number of half-cycles (`WIN_HALF`, default 6) before their enables turn off. Grant, precharge request and busy are never tri-stated by this block.

The state machine has eight states:

| State | Role | Leaves to |
|---|---|---|
| `ST_OWN` | Master owns the bus. | `ST_DRAIN`, on a falling edge that sees the request. |
| `ST_DRAIN` | Waits for the current cycle to end. | `ST_OWN` on cancel, or `ST_PCHG_ISSUE` once `cycle_idle` is high. |
| `ST_PCHG_ISSUE` | Precharge strobe, one half-cycle long. | `ST_OWN` on cancel, otherwise `ST_PCHG_WAIT`. |
| `ST_PCHG_WAIT` | Waits for precharge done and the negation window. Acts only on falling edges. | `ST_OWN` on cancel, or `ST_GRANTED` when both are met. |
| `ST_GRANTED` | Grant is low and all enables are still on. | `ST_AD_OFF` on the next rising edge. |
| `ST_AD_OFF` | Address and data are floated. | `ST_RELEASED` on the next falling edge. |
| `ST_RELEASED` | All three groups are floated. | `ST_RECLAIM` on a falling edge that sees the request negated. |
| `ST_RECLAIM` | Grant is high and control is driven again. | `ST_OWN` on the next rising edge, which re-drives address and data. |

Top module: `bus_release_arb`

## Requirements
- R1: While reset (synchronous, active low) is held: grant_n=1; addr_oe, data_oe and ctrl_oe are 1; bus_busy, pchg_req and ctrl_negate are 0; next_is_fall=1.
- R2: rel_req_n is sampled only on falling edges (edges for which next_is_fall was 1). A request that is low only across a rising edge has no effect, and a withdrawal seen only at a rising edge is ignored.
- R3: bus_busy goes high on the falling edge that samples rel_req_n=0. grant_n stays 1 for as long as cycle_idle is 0, and grant_n=0 implies bus_busy=1.
- R4: pchg_req is high for exactly one half-cycle, on the edge after cycle_idle is seen high. The grant is then withheld until pchg_done is high.
- R5: grant_n falls only on a falling edge. ctrl_negate is high for at least WIN_HALF half-cycles before ctrl_oe falls.
- R6: Release order: grant_n goes to 0 on a falling edge with all enables on. addr_oe and data_oe go to 0 on the next (rising) edge. ctrl_oe goes to 0 on the following (falling) edge.
- R7: While rel_req_n stays 0 after release, grant_n=0 and all three enables stay 0.
- R8: On the falling edge that samples rel_req_n=1 in the released state, grant_n goes to 1 and ctrl_oe goes to 1, with addr_oe and data_oe still 0. On the next edge, addr_oe and data_oe go to 1 and bus_busy goes to 0.
- R9: If rel_req_n=1 is sampled on a falling edge before the grant is given, the block returns to owning the bus. bus_busy and ctrl_negate drop to 0, grant_n never goes low, and the enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the bus rate; each edge is one bus half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rel_req_n | input | 1 | Active-low bus release request from the external device |
| cycle_idle | input | 1 | High when no master bus cycle is in progress |
| pchg_done | input | 1 | High when memory precharge has completed |
| grant_n | output | 1 | Active-low bus grant |
| addr_oe | output | 1 | Output enable for the address group |
| data_oe | output | 1 | Output enable for the data group |
| ctrl_oe | output | 1 | Output enable for the control-strobe group |
| ctrl_negate | output | 1 | Forces control strobes to their negated level |
| pchg_req | output | 1 | One-half-cycle precharge request strobe |
| bus_busy | output | 1 | Blocks new master cycles during release and reclaim |
| next_is_fall | output | 1 | High when the next clk2x edge is a falling bus edge |

## Verification
Two situations are hard to reach from the ports.

The first is the negation window actually delaying the grant. Waiting on precharge usually hides the window, because by the time precharge ends the window is long met. The stimulus therefore holds `cycle_idle` and `pchg_done` high before raising the request. With nothing else to wait on, the window alone sets the grant edge, and the bench counts half-cycles from `ctrl_negate` rising to `ctrl_oe` falling.

The second is a withdrawal that lands on the wrong edge. The bench aligns its stimulus to `next_is_fall`, so that a request or a withdrawal lasts across exactly one rising edge. It then checks that this edge changes nothing.

// File: rtl/brq_pkg.sv
package brq_pkg;

    typedef enum logic [2:0] {
        ST_OWN,
        ST_DRAIN,
        ST_PCHG_ISSUE,
        ST_PCHG_WAIT,
        ST_GRANTED,
        ST_AD_OFF,
        ST_RELEASED,
        ST_RECLAIM
    } arb_state_e;

endpackage

// File: rtl/brq_phase.sv
module brq_phase (
    input  logic clk2x,
    input  logic rst_n,
    output logic fall_now
);

    // fall_now: the edge now being taken stands for a falling bus edge.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            fall_now <= 1'b1;
        end else begin
            fall_now <= ~fall_now;
        end
    end

endmodule

// File: rtl/brq_negwin.sv
module brq_negwin #(
    parameter int WIN_HALF = 6
) (
    input  logic                                 clk2x,
    input  logic                                 rst_n,
    input  logic                                 negating,
    output logic [$clog2(WIN_HALF + 1) - 1 : 0]  neg_cnt,
    output logic                                 win_ok
);

    localparam int CW = $clog2(WIN_HALF + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(WIN_HALF);
    // The enables of the control group turn off two half-cycles after the grant edge.
    localparam int GRANT_LEAD = 3;

    // neg_cnt holds the number of edges taken since ctrl_negate went high.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            neg_cnt <= '0;
        end else if (negating) begin
            if (neg_cnt != CNT_MAX) begin
                neg_cnt <= neg_cnt + 1'b1;
            end
        end else begin
            neg_cnt <= '0;
        end
    end

    always_comb begin
        win_ok = (int'(neg_cnt) + GRANT_LEAD) >= WIN_HALF;
    end

endmodule

// File: rtl/brq_fsm.sv
module brq_fsm
    import brq_pkg::*;
(
    input  logic clk2x,
    input  logic rst_n,
    input  logic fall_now,
    input  logic rel_req_n,
    input  logic cycle_idle,
    input  logic pchg_done,
    input  logic win_ok,
    output logic grant_n,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic ctrl_negate,
    output logic pchg_req,
    output logic bus_busy
);

    arb_state_e state_q, state_d;

    logic req_seen;
    logic wd_seen;

    always_comb begin
        req_seen = fall_now && !rel_req_n;
        wd_seen  = fall_now &&  rel_req_n;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN: begin
                if (req_seen) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wd_seen)         state_d = ST_OWN;
                else if (cycle_idle) state_d = ST_PCHG_ISSUE;
            end
            ST_PCHG_ISSUE: begin
                if (wd_seen) state_d = ST_OWN;
                else         state_d = ST_PCHG_WAIT;
            end
            ST_PCHG_WAIT: begin
                if (wd_seen)                               state_d = ST_OWN;
                else if (fall_now && pchg_done && win_ok)  state_d = ST_GRANTED;
            end
            ST_GRANTED: begin
                if (!fall_now) state_d = ST_AD_OFF;
            end
            ST_AD_OFF: begin
                if (fall_now) state_d = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (wd_seen) state_d = ST_RECLAIM;
            end
            ST_RECLAIM: begin
                if (!fall_now) state_d = ST_OWN;
            end
            default: state_d = ST_OWN;
        endcase
    end

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            state_q <= ST_OWN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        grant_n     = 1'b1;
        addr_oe     = 1'b1;
        data_oe     = 1'b1;
        ctrl_oe     = 1'b1;
        ctrl_negate = 1'b0;
        pchg_req    = 1'b0;
        bus_busy    = 1'b1;
        unique case (state_q)
            ST_OWN: begin
                bus_busy = 1'b0;
            end
            ST_DRAIN: begin
            end
            ST_PCHG_ISSUE: begin
                ctrl_negate = 1'b1;
                pchg_req    = 1'b1;
            end
            ST_PCHG_WAIT: begin
                ctrl_negate = 1'b1;
            end
            ST_GRANTED: begin
                ctrl_negate = 1'b1;
                grant_n     = 1'b0;
            end
            ST_AD_OFF: begin
                ctrl_negate = 1'b1;
                grant_n     = 1'b0;
                addr_oe     = 1'b0;
                data_oe     = 1'b0;
            end
            ST_RELEASED: begin
                ctrl_negate = 1'b1;
                grant_n     = 1'b0;
                addr_oe     = 1'b0;
                data_oe     = 1'b0;
                ctrl_oe     = 1'b0;
            end
            ST_RECLAIM: begin
                ctrl_negate = 1'b1;
                addr_oe     = 1'b0;
                data_oe     = 1'b0;
            end
            default: begin
                bus_busy = 1'b0;
            end
        endcase
    end

    AST_BUSY_ON_FALL: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(fall_now)); // R2

    AST_GRANT_NEEDS_BUSY: assert property (@(posedge clk2x) disable iff (!rst_n)
        !grant_n |-> bus_busy); // R3

    AST_PCHG_SINGLE: assert property (@(posedge clk2x) disable iff (!rst_n)
        pchg_req |=> !pchg_req); // R4

    AST_GRANT_ON_FALL: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(grant_n) |-> $past(fall_now)); // R5

    AST_AD_AFTER_GRANT: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(addr_oe) |-> (!grant_n && $past(!grant_n))); // R6

    AST_CTL_AFTER_AD: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(ctrl_oe) |-> (!addr_oe && $past(!addr_oe))); // R6

    AST_RECLAIM_ORDER: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(grant_n) |-> (ctrl_oe && !addr_oe && !data_oe)); // R8

    AST_AD_BACK_AFTER_CTL: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(addr_oe) |-> ($past(ctrl_oe) && grant_n && !bus_busy)); // R8

endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb #(
    parameter int WIN_HALF = 6
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic rel_req_n,
    input  logic cycle_idle,
    input  logic pchg_done,
    output logic grant_n,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic ctrl_negate,
    output logic pchg_req,
    output logic bus_busy,
    output logic next_is_fall
);

    localparam int CW = $clog2(WIN_HALF + 1);

    logic          fall_now;
    logic          win_ok;
    logic [CW-1:0] neg_cnt;

    brq_phase u_phase (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .fall_now (fall_now)
    );

    brq_negwin #(
        .WIN_HALF (WIN_HALF)
    ) u_negwin (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .negating (ctrl_negate),
        .neg_cnt  (neg_cnt),
        .win_ok   (win_ok)
    );

    brq_fsm u_fsm (
        .clk2x       (clk2x),
        .rst_n       (rst_n),
        .fall_now    (fall_now),
        .rel_req_n   (rel_req_n),
        .cycle_idle  (cycle_idle),
        .pchg_done   (pchg_done),
        .win_ok      (win_ok),
        .grant_n     (grant_n),
        .addr_oe     (addr_oe),
        .data_oe     (data_oe),
        .ctrl_oe     (ctrl_oe),
        .ctrl_negate (ctrl_negate),
        .pchg_req    (pchg_req),
        .bus_busy    (bus_busy)
    );

    always_comb begin
        next_is_fall = fall_now;
    end

    AST_NEG_WINDOW: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(ctrl_oe) |-> (int'(neg_cnt) >= WIN_HALF)); // R5

endmodule

// File: tb/bus_release_arb_bench.sv
module bus_release_arb_bench;

    localparam int WIN = 6;

    logic clk2x = 1'b0;
    logic rst_n;
    logic rel_req_n;
    logic cycle_idle;
    logic pchg_done;
    logic grant_n, addr_oe, data_oe, ctrl_oe, ctrl_negate, pchg_req, bus_busy, next_is_fall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk2x = ~clk2x;

    bus_release_arb #(.WIN_HALF(WIN)) u_bus_release_arb (
        .clk2x        (clk2x),
        .rst_n        (rst_n),
        .rel_req_n    (rel_req_n),
        .cycle_idle   (cycle_idle),
        .pchg_done    (pchg_done),
        .grant_n      (grant_n),
        .addr_oe      (addr_oe),
        .data_oe      (data_oe),
        .ctrl_oe      (ctrl_oe),
        .ctrl_negate  (ctrl_negate),
        .pchg_req     (pchg_req),
        .bus_busy     (bus_busy),
        .next_is_fall (next_is_fall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk2x);
        @(negedge clk2x);
    endtask

    task automatic to_fall();
        while (!next_is_fall) tick();
    endtask

    task automatic to_rise();
        while (next_is_fall) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rel_req_n = 1'b1; cycle_idle = 1'b1; pchg_done = 1'b1;
        repeat (3) tick();
        chk("R1 grant_n", grant_n, 1);
        chk("R1 enables", {addr_oe, data_oe, ctrl_oe}, 3'b111);
        chk("R1 busy/pchg/negate", {bus_busy, pchg_req, ctrl_negate}, 0);
        chk("R1 next_is_fall", next_is_fall, 1);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_rise_only();
        to_rise();
        rel_req_n = 1'b0;
        tick();
        rel_req_n = 1'b1;
        chk("R2 busy after rise-only request", bus_busy, 0);
        tick();
        chk("R2 busy after next fall", bus_busy, 0);
        chk("R2 grant_n unchanged", grant_n, 1);
    endtask

    task automatic t_release();
        int halves;
        bit was_fall;
        to_fall();
        rel_req_n = 1'b0; cycle_idle = 1'b0; pchg_done = 1'b0;
        tick();
        chk("R3 busy on sampling fall", bus_busy, 1);
        chk("R3 negate not yet", ctrl_negate, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R3 no grant during cycle", grant_n, 1);
        end
        cycle_idle = 1'b1;
        tick();
        chk("R4 pchg_req strobe", pchg_req, 1);
        chk("R5 negate started", ctrl_negate, 1);
        halves = 0;
        tick(); halves++;
        chk("R4 pchg_req one half-cycle", pchg_req, 0);
        for (int i = 0; i < 6; i++) begin
            tick(); halves++;
            chk("R4 grant withheld for precharge", grant_n, 1);
        end
        pchg_done = 1'b1;
        was_fall = 1'b0;
        for (int i = 0; i < 40 && grant_n; i++) begin
            was_fall = next_is_fall;
            tick(); halves++;
        end
        chk("R5 grant taken on fall edge", was_fall, 1);
        chk("R6 grant asserted", grant_n, 0);
        chk("R6 enables on at grant", {addr_oe, data_oe, ctrl_oe}, 3'b111);
        tick(); halves++;
        chk("R6 addr/data off next edge", {addr_oe, data_oe, ctrl_oe}, 3'b001);
        tick(); halves++;
        chk("R6 ctrl off following edge", ctrl_oe, 0);
        chk("R5 negation window", int'(halves >= WIN), 1);
        for (int i = 0; i < 5; i++) tick();
        chk("R7 grant held", grant_n, 0);
        chk("R7 enables held off", {addr_oe, data_oe, ctrl_oe}, 0);
    endtask

    task automatic t_reclaim();
        to_rise();
        rel_req_n = 1'b1;
        tick();
        chk("R2 withdrawal at rise ignored", grant_n, 0);
        chk("R8 still released", {addr_oe, data_oe, ctrl_oe}, 0);
        tick();
        chk("R8 grant negated", grant_n, 1);
        chk("R8 ctrl on, addr/data off", {addr_oe, data_oe, ctrl_oe}, 3'b001);
        chk("R8 busy during reclaim", bus_busy, 1);
        tick();
        chk("R8 addr/data back", {addr_oe, data_oe, ctrl_oe}, 3'b111);
        chk("R8 busy cleared", bus_busy, 0);
    endtask

    task automatic t_cancel(input bit in_drain);
        bit grant_seen;
        to_fall();
        rel_req_n = 1'b0; cycle_idle = !in_drain; pchg_done = 1'b0;
        tick();
        chk("R9 busy after request", bus_busy, 1);
        grant_seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (!grant_n) grant_seen = 1'b1;
        end
        to_fall();
        rel_req_n = 1'b1;
        tick();
        if (!grant_n) grant_seen = 1'b1;
        chk("R9 busy dropped", bus_busy, 0);
        chk("R9 negate dropped", ctrl_negate, 0);
        chk("R9 grant never low", grant_seen, 0);
        chk("R9 enables stayed on", {addr_oe, data_oe, ctrl_oe}, 3'b111);
        cycle_idle = 1'b1; pchg_done = 1'b1;
        tick(); tick();
    endtask

    task automatic t_fast_window();
        int h;
        bit was_fall;
        cycle_idle = 1'b1; pchg_done = 1'b1;
        to_fall();
        rel_req_n = 1'b0;
        h = -1;
        was_fall = 1'b0;
        for (int i = 0; i < 40 && ctrl_oe; i++) begin
            if (grant_n) was_fall = next_is_fall;
            tick();
            if (h >= 0) h++;
            else if (ctrl_negate) h = 0;
        end
        chk("R5 grant edge is fall (fast path)", was_fall, 1);
        chk("R5 window met (fast path)", int'(h >= WIN), 1);
        chk("R6 released (fast path)", {grant_n, ctrl_oe}, 0);
        to_fall();
        rel_req_n = 1'b1;
        tick(); tick();
        chk("R8 back to own (fast path)", {grant_n, bus_busy, addr_oe}, 3'b101);
    endtask

    initial begin
        t_reset();
        t_rise_only();
        t_release();
        t_reclaim();
        t_cancel(1'b0);
        t_cancel(1'b1);
        t_fast_window();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk2x);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule